// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block holds the replacement state of a set-associative cache and names the way to evict when a line must be filled. For every set it keeps one bit for each internal node of a binary tree over the ways, `NUM_WAYS-1` bits in all. Each node bit says which of its two subtrees is the older one, meaning the one used less recently. The tree keeps only a partial age order. It does not keep a full recency stack.

An access port reports each hit or fill as a set index and a way, qualified by a valid strobe. The block then rewrites the node bits on the root-to-leaf path of that way so that each of them points away from it. A separate query port takes a set index and returns, in the same cycle, the victim way. The block finds it by walking from the root along the older-half pointers. The way count is a power-of-two parameter. With two ways the tree is a single bit per set.

Top module: `plru_victim_sel`

## Requirements
- R1: After a synchronous reset, every set returns way 0 as its victim. This holds both at start-up and when reset is applied mid-run.
- R2: After an access to way w of a set, that set never names w as its victim, starting in the next cycle.
- R3: Node bits are numbered heap-style: the root is node 0, and the children of node i are 2i+1 (left, lower ways) and 2i+2 (right). A node value of 0 sends the walk left and a value of 1 sends it right. The victim index is built most-significant bit first from the root's decision. After reset, an access to way 0 makes way 4 the victim.
- R4: When all ways of a set are accessed in ascending order, the victim becomes way 0. When they are accessed in descending order, it becomes way 7.
- R5: An access changes the state of the addressed set only. The victims of all other sets are unaffected.
- R6: When the valid strobe is low, the set and way on the access port have no effect.
- R7: An access takes effect at the next clock edge. A query to the same set in the same cycle returns the victim computed from the state before the update.
- R8: With two ways, the victim is always the way not accessed most recently. This is exact LRU.
- R9: Repeating an access to the way that was just accessed leaves the victim unchanged.
- R10: For the access sequence 0,4,2,6,1,5,3,7,0,4 on one set from reset, the victims after each access are 4,2,6,1,5,3,7,0,4,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears every set |
| acc_valid | input | 1 | Qualifies the access port |
| acc_set | input | $clog2(NUM_SETS) | Set index of the hit or fill |
| acc_way | input | $clog2(NUM_WAYS) | Way that was hit or filled |
| qry_set | input | $clog2(NUM_SETS) | Set index to pick a victim from |
| victim_way | output | $clog2(NUM_WAYS) | Pseudo-LRU way of the queried set |

## Verification
A wrong node bit shows up at the victim output as soon as the affected set is queried, which can be the cycle after the faulty access. The error stays hidden until the walk actually passes through the wrong node, so the access sequence is chosen to steer the walk through every node of the tree. A wrong update path or inverted polarity shows within one access of the known sequence. State leaking into the wrong set shows when an untouched set is queried. An off-by-one in timing shows when an access and a query hit the same set in the same cycle.

// File: rtl/plru_pkg.sv
package plru_pkg;

    typedef enum logic {
        GO_LEFT  = 1'b0,
        GO_RIGHT = 1'b1
    } plru_dir_e;

    // Heap-style child index: left child 2i+1, right child 2i+2.
    function automatic int unsigned child_idx(input int unsigned node, input plru_dir_e dir);
        return 2 * node + 1 + ((dir == GO_RIGHT) ? 1 : 0);
    endfunction

    // Direction that points away from the way whose path bit is b.
    function automatic plru_dir_e away_from(input logic b);
        return b ? GO_LEFT : GO_RIGHT;
    endfunction

endpackage

// File: rtl/plru_tree_walk.sv
module plru_tree_walk
    import plru_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int LEVELS  = $clog2(NUM_WAYS),
    localparam int NODES   = NUM_WAYS - 1
) (
    input  logic [NODES-1:0]  row,
    output logic [LEVELS-1:0] victim
);

    generate
        if (LEVELS == 1) begin : g_single
            // One node: its value is the older way directly.
            assign victim = row;
        end else begin : g_tree
            always_comb begin
                int unsigned node;
                plru_dir_e   dir;
                node   = 0;
                victim = '0;
                for (int lvl = 0; lvl < LEVELS; lvl++) begin
                    dir = plru_dir_e'(row[node]);
                    victim[LEVELS-1-lvl] = dir;
                    node = child_idx(node, dir);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/plru_tree_update.sv
module plru_tree_update
    import plru_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int LEVELS  = $clog2(NUM_WAYS),
    localparam int NODES   = NUM_WAYS - 1
) (
    input  logic [NODES-1:0]  row_in,
    input  logic [LEVELS-1:0] way,
    output logic [NODES-1:0]  row_out
);

    always_comb begin
        int unsigned node;
        logic        bit_here;
        row_out = row_in;
        node    = 0;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            bit_here      = way[LEVELS-1-lvl];
            row_out[node] = away_from(bit_here);
            node          = child_idx(node, plru_dir_e'(bit_here));
        end
    end

    // R5: an update rewrites no more than one node per tree level
    always_comb begin
        if (!$isunknown({row_in, way}))
            assert_path_only_R5: assert ($countones(row_in ^ row_out) <= LEVELS);
    end

endmodule

// File: rtl/plru_state_array.sv
module plru_state_array #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 16,
    localparam int NODES   = NUM_WAYS - 1,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [NODES-1:0] wr_row,
    input  logic [SET_W-1:0] rd_upd_set,
    output logic [NODES-1:0] rd_upd_row,
    input  logic [SET_W-1:0] rd_qry_set,
    output logic [NODES-1:0] rd_qry_row
);

    logic [NODES-1:0] rows [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) rows[s] <= '0;
        end else if (wr_en) begin
            rows[wr_set] <= wr_row;
        end
    end

    assign rd_upd_row = rows[rd_upd_set];
    assign rd_qry_row = rows[rd_qry_set];

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_hold
            // R5 / R6: a set not addressed by a valid write keeps its state
            assert_idle_set_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && wr_set == SET_W'(s)) |=> $stable(rows[s]));
        end
    endgenerate

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 16,
    localparam int LEVELS  = $clog2(NUM_WAYS),
    localparam int NODES   = NUM_WAYS - 1,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [LEVELS-1:0] acc_way,
    input  logic [SET_W-1:0]  qry_set,
    output logic [LEVELS-1:0] victim_way
);

    logic [NODES-1:0] cur_row;
    logic [NODES-1:0] nxt_row;
    logic [NODES-1:0] qry_row;

    plru_state_array #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_state (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (acc_valid),
        .wr_set     (acc_set),
        .wr_row     (nxt_row),
        .rd_upd_set (acc_set),
        .rd_upd_row (cur_row),
        .rd_qry_set (qry_set),
        .rd_qry_row (qry_row)
    );

    plru_tree_update #(.NUM_WAYS(NUM_WAYS)) u_update (
        .row_in  (cur_row),
        .way     (acc_way),
        .row_out (nxt_row)
    );

    plru_tree_walk #(.NUM_WAYS(NUM_WAYS)) u_walk (
        .row    (qry_row),
        .victim (victim_way)
    );

    // R1: the first cycle out of reset names way 0 for any set
    assert_reset_victim_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> victim_way == '0);

    // R2: the way just touched is not the victim of that set
    assert_touched_not_victim_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(acc_valid) && qry_set == $past(acc_set))
            |-> victim_way != $past(acc_way));

    generate
        if (NUM_WAYS == 2) begin : g_two_way_chk
            // R8: two ways behave as exact LRU
            assert_two_way_lru_R8: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(acc_valid) && qry_set == $past(acc_set))
                    |-> victim_way == ~$past(acc_way));
        end
    endgenerate

endmodule

// File: tb/tb_plru_victim_sel.sv
module tb_plru_victim_sel;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst;
    logic       acc_valid;
    logic [3:0] acc_set;
    logic [2:0] acc_way;
    logic [3:0] qry_set;
    logic [2:0] victim_way;

    logic       acc_valid2;
    logic [1:0] acc_set2;
    logic       acc_way2;
    logic [1:0] qry_set2;
    logic       victim_way2;

    plru_victim_sel #(.NUM_WAYS(8), .NUM_SETS(16)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way)
    );

    plru_victim_sel #(.NUM_WAYS(2), .NUM_SETS(4)) dut2 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid2), .acc_set(acc_set2),
        .acc_way(acc_way2), .qry_set(qry_set2), .victim_way(victim_way2)
    );

    typedef struct packed {
        logic [2:0] way;
        logic [2:0] exp_victim;
    } vec_t;

    // R10 sequence on set 3 from reset (first entry also covers R3)
    localparam vec_t VEC [10] = '{
        '{3'd0, 3'd4}, '{3'd4, 3'd2}, '{3'd2, 3'd6}, '{3'd6, 3'd1}, '{3'd1, 3'd5},
        '{3'd5, 3'd3}, '{3'd3, 3'd7}, '{3'd7, 3'd0}, '{3'd0, 3'd4}, '{3'd4, 3'd2}
    };

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got %0d cycles expected < 20000", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negative edge; returns at the next negative edge.
    task automatic touch(input int s, input int w);
        acc_valid = 1'b1;
        acc_set   = 4'(s);
        acc_way   = 3'(w);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic touch2(input int s, input int w);
        acc_valid2 = 1'b1;
        acc_set2   = 2'(s);
        acc_way2   = 1'(w);
        @(posedge clk);
        @(negedge clk);
        acc_valid2 = 1'b0;
    endtask

    task automatic look(input int s, output int v);
        qry_set = 4'(s);
        #1;
        v = int'(victim_way);
    endtask

    task automatic look2(input int s, output int v);
        qry_set2 = 2'(s);
        #1;
        v = int'(victim_way2);
    endtask

    initial begin
        int v;
        rst = 1'b1; acc_valid = 1'b0; acc_set = '0; acc_way = '0; qry_set = '0;
        acc_valid2 = 1'b0; acc_set2 = '0; acc_way2 = '0; qry_set2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        look(0, v);  chk("R1 set0", v, 0);
        look(5, v);  chk("R1 set5", v, 0);
        look(15, v); chk("R1 set15", v, 0);

        // R10 / R3: table walk on set 3
        foreach (VEC[i]) begin
            touch(3, int'(VEC[i].way));
            look(3, v);
            chk($sformatf("R10 step%0d", i), v, int'(VEC[i].exp_victim));
        end

        // R5: set 9 untouched by the set-3 traffic
        look(9, v); chk("R5 set9", v, 0);

        // R6: access with valid low to set 9 way 0 has no effect
        acc_valid = 1'b0; acc_set = 4'd9; acc_way = 3'd0;
        @(posedge clk); @(negedge clk);
        look(9, v); chk("R6 set9", v, 0);

        // R7: same-cycle access and query on set 3 (victim currently 2)
        acc_valid = 1'b1; acc_set = 4'd3; acc_way = 3'd2; qry_set = 4'd3;
        #1; chk("R7 pre-update", int'(victim_way), 2);
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        look(3, v); chk("R7 post-update", v, 6);

        // R9: repeating the last way keeps the victim
        touch(3, 2);
        look(3, v); chk("R9 repeat", v, 6);

        // R4: ascending fill on set 7, descending on set 8
        for (int w = 0; w < 8; w++) touch(7, w);
        look(7, v); chk("R4 ascending", v, 0);
        for (int w = 7; w >= 0; w--) touch(8, w);
        look(8, v); chk("R4 descending", v, 7);

        // R2: touched way is never the victim
        for (int w = 0; w < 8; w++) begin
            touch(11, (w * 3) % 8);
            look(11, v);
            n_chk++;
            if (v == (w * 3) % 8) begin
                n_err++;
                $display("FAIL R2 way%0d: got %0d expected not %0d", (w * 3) % 8, v, (w * 3) % 8);
            end
        end

        // R8: two-way instance
        look2(1, v); chk("R8 reset", v, 0);
        touch2(1, 0); look2(1, v); chk("R8 after way0", v, 1);
        touch2(1, 1); look2(1, v); chk("R8 after way1", v, 0);
        touch2(1, 1); look2(1, v); chk("R8 repeat way1", v, 0);
        look2(2, v); chk("R8 other set", v, 0);

        // R1: reset mid-run clears set 3 and set 11
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        look(3, v);  chk("R1 midrun set3", v, 0);
        look(11, v); chk("R1 midrun set11", v, 0);

        summary();
    end

endmodule